// File: doc/BRIEF.md
# Command-Driven Register Page Mapper

This block sits between the host's register address decoder and the register file of a peripheral that can run in one of two emulation personalities. On every host access it turns the raw register address and the read/write strobes into a remapped register select. That select names either an ordinary register, one of a small set of hidden registers, or nothing at all. The personality is chosen once, from a mode pin, while reset is held.

In the second personality, one write-only address (the paging address) selects nothing until software writes a page-in opcode to the auxiliary command address. From then on, host writes at the paging address go to the hidden writable register chosen by that opcode. Two hidden readable registers also become visible: one at the paging address and one at a companion peer address. A clear opcode withdraws all of them again. In the first personality the opcodes have no effect on paging. An external page pin maps the hidden registers in directly for as long as it is held high.

The contents of the registers themselves live elsewhere. This block only produces the select and the page state.

Top module: `page_mapper`

## Requirements
- R1: While reset is low at a clock edge, the page state is cleared. After reset in the second personality, page_active_o is 0 and page_slot_o is 0, and any earlier page-in has been discarded.
- R2: The personality is captured from mode_pin at each clock edge while rst_n is low: high gives the first personality (first_mode_o=1), low gives the second. Changes on mode_pin while rst_n is high have no effect.
- R3: In the second personality with no page selected, a write at the paging address (5'h0D) drives sel_valid_o=0. A read at that address is an ordinary access (sel_valid_o=1, sel_hidden_o=0, sel_idx_o=5'h0D).
- R4: In the second personality, a write of opcode 8'h50+k (k=0..3) at the auxiliary command address (5'h05) sets page_active_o=1 and page_slot_o=k from the next cycle. After that, writes at the paging address give sel_valid_o=1, sel_hidden_o=1 and sel_idx_o=k.
- R5: A new page-in opcode replaces the previous selection, so later writes at the paging address go only to the newest slot.
- R6: While any page is active, a read at the paging address selects hidden index 4 and a read at the peer address (5'h0A) selects hidden index 5, both with sel_hidden_o=1.
- R7: Opcode 8'h54 at the auxiliary address clears page_active_o from the next cycle. Writes at the paging address then select nothing again, and reads at the peer address are ordinary.
- R8: Any other opcode written at the auxiliary address leaves page_active_o and page_slot_o unchanged.
- R9: In the first personality, page_active_o follows page_pin and page_slot_o is 0. With the pin high, a paging-address write selects hidden index 0 and reads select hidden indices 4 and 5 as in R6. Opcodes at the auxiliary address never change the paging.
- R10: With neither strobe high, sel_valid_o=0. An access at any address other than the paging or peer address passes through as ordinary, with sel_idx_o equal to host_addr. When both strobes are high, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pin | input | 1 | Personality select, captured during reset |
| page_pin | input | 1 | Direct page-in control used in the first personality |
| host_addr | input | 5 | Host register address |
| rd_stb | input | 1 | Host read strobe |
| wr_stb | input | 1 | Host write strobe |
| cmd_byte | input | 8 | Host write data, decoded as an opcode at the auxiliary address |
| sel_valid_o | output | 1 | The access selects a register |
| sel_hidden_o | output | 1 | The selected register is a hidden (paged) one |
| sel_idx_o | output | 5 | Ordinary register address or hidden register index |
| page_active_o | output | 1 | Hidden registers are currently mapped in |
| page_slot_o | output | 2 | Hidden writable register chosen for paging-address writes |
| first_mode_o | output | 1 | Captured personality, 1 = first |

## Verification
The checker watches several things on every cycle. It checks that an idle bus never produces a select. It checks that an unpaged write at the paging address selects nothing. It checks that paged reads land on hidden indices 4 and 5. It checks the one-cycle effect of page-in, clear and unknown opcodes on the page state, and that the captured personality holds still outside reset. Some behaviour only the bench's ordered scenarios can show. These are the replacement of one slot by the next across a sequence of writes, the discarding of a page selection by a later reset, and the page pin's takeover of paging in the first personality while opcodes are ignored.

// File: rtl/pm_pkg.sv
// Shared definitions for the register page mapper.
// Assumes: at most a handful of hidden writable slots, so slot indices and the
// two readable hidden indices fit in the host address width.
package pm_pkg;

    // Number of hidden writable registers reachable through page-in opcodes.
    localparam int PM_SLOTS  = 4;
    localparam int PM_SLOT_W = (PM_SLOTS > 1) ? $clog2(PM_SLOTS) : 1;

    // Kind of host access seen in the current cycle.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    // Registered paging state.
    typedef struct packed {
        logic                 active;
        logic [PM_SLOT_W-1:0] slot;
    } page_st_t;

endpackage

// File: rtl/pm_mode_latch.sv
// Captures the emulation personality from the mode pin.
// Assumes: the mode pin is stable during the last reset cycle; the captured
// value is frozen for as long as reset stays released.
module pm_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_pin,
    output logic first_mode
);

    // Sample the pin on every edge of reset, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_mode <= mode_pin;
        end
    end

endmodule

// File: rtl/pm_cmd_decode.sv
// Decodes an auxiliary command byte into page-in or clear requests.
// Assumes: page-in opcodes form one contiguous run starting at PAGE_BASE with
// SLOTS members, and the clear opcode lies outside that run.
module pm_cmd_decode #(
    parameter int             CMD_W      = 8,
    parameter int             SLOTS      = pm_pkg::PM_SLOTS,
    parameter logic [CMD_W-1:0] PAGE_BASE  = 8'h50,
    parameter logic [CMD_W-1:0] CLEAR_CODE = 8'h54
) (
    input  logic [CMD_W-1:0]            cmd,
    output logic                        is_pagein,
    output logic                        is_clear,
    output logic [pm_pkg::PM_SLOT_W-1:0] slot
);

    localparam int SLOT_W = pm_pkg::PM_SLOT_W;
    localparam logic [CMD_W-1:0] SLOT_LIMIT = CMD_W'(SLOTS);

    logic [CMD_W-1:0] offset;

    // Classify the opcode and derive the slot it names.
    always_comb begin
        offset    = cmd - PAGE_BASE;
        is_pagein = (cmd >= PAGE_BASE) && (offset < SLOT_LIMIT);
        is_clear  = (cmd == CLEAR_CODE);
        slot      = offset[SLOT_W-1:0];
    end

endmodule

// File: rtl/pm_page_state.sv
// Holds which hidden writable register, if any, is paged in.
// Assumes: cmd_wr is already qualified by personality and address, and a
// page-in request and a clear request never arrive together.
module pm_page_state (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_wr,
    input  logic                          is_pagein,
    input  logic                          is_clear,
    input  logic [pm_pkg::PM_SLOT_W-1:0]  slot_in,
    output pm_pkg::page_st_t              state
);

    import pm_pkg::*;

    // Reset clears paging; page-in replaces the slot; clear withdraws it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
        end else if (cmd_wr && is_pagein) begin
            state.active <= 1'b1;
            state.slot   <= slot_in;
        end else if (cmd_wr && is_clear) begin
            state <= '0;
        end
    end

endmodule

// File: rtl/pm_addr_remap.sv
// Turns a host access into a remapped register select.
// Assumes: hidden writable registers are numbered 0..SLOTS-1, and the two
// readable hidden registers follow them as SLOTS and SLOTS+1.
module pm_addr_remap #(
    parameter int                ADDR_W    = 5,
    parameter int                SLOTS     = pm_pkg::PM_SLOTS,
    parameter logic [ADDR_W-1:0] PAGE_ADDR = 5'h0D,
    parameter logic [ADDR_W-1:0] PEER_ADDR = 5'h0A
) (
    input  logic                          first_mode,
    input  logic                          paged,
    input  logic [pm_pkg::PM_SLOT_W-1:0]  slot,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          rd,
    input  logic                          wr,
    output logic                          valid,
    output logic                          hidden,
    output logic [ADDR_W-1:0]             idx
);

    import pm_pkg::*;

    localparam logic [ADDR_W-1:0] RD_A_IDX = ADDR_W'(SLOTS);
    localparam logic [ADDR_W-1:0] RD_B_IDX = ADDR_W'(SLOTS + 1);

    acc_e acc;

    // Classify the strobes; a write wins when both are high.
    always_comb begin
        if (wr)      acc = ACC_WRITE;
        else if (rd) acc = ACC_READ;
        else         acc = ACC_NONE;
    end

    // Redirect the paging and peer addresses; pass the rest through.
    always_comb begin
        valid  = (acc != ACC_NONE);
        hidden = 1'b0;
        idx    = addr;
        if (paged) begin
            if (acc == ACC_WRITE && addr == PAGE_ADDR) begin
                hidden = 1'b1;
                idx    = ADDR_W'(slot);
            end else if (acc == ACC_READ && addr == PAGE_ADDR) begin
                hidden = 1'b1;
                idx    = RD_A_IDX;
            end else if (acc == ACC_READ && addr == PEER_ADDR) begin
                hidden = 1'b1;
                idx    = RD_B_IDX;
            end
        end else if (!first_mode && acc == ACC_WRITE && addr == PAGE_ADDR) begin
            valid = 1'b0;
        end
    end

endmodule

// File: rtl/page_mapper.sv
// Top of the register page mapper: personality capture, opcode decode,
// page state and address remap.
// Assumes: one host access per cycle, strobes sampled on the clock, and a
// synchronous active-low reset long enough to capture the mode pin.
module page_mapper #(
    parameter int                ADDR_W     = 5,
    parameter int                CMD_W      = 8,
    parameter logic [ADDR_W-1:0] AUX_ADDR   = 5'h05,
    parameter logic [ADDR_W-1:0] PAGE_ADDR  = 5'h0D,
    parameter logic [ADDR_W-1:0] PEER_ADDR  = 5'h0A,
    parameter logic [CMD_W-1:0]  PAGE_BASE  = 8'h50,
    parameter logic [CMD_W-1:0]  CLEAR_CODE = 8'h54
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_pin,
    input  logic                          page_pin,
    input  logic [ADDR_W-1:0]             host_addr,
    input  logic                          rd_stb,
    input  logic                          wr_stb,
    input  logic [CMD_W-1:0]              cmd_byte,
    output logic                          sel_valid_o,
    output logic                          sel_hidden_o,
    output logic [ADDR_W-1:0]             sel_idx_o,
    output logic                          page_active_o,
    output logic [pm_pkg::PM_SLOT_W-1:0]  page_slot_o,
    output logic                          first_mode_o
);

    import pm_pkg::*;

    logic                 first_mode;
    logic                 is_pagein;
    logic                 is_clear;
    logic [PM_SLOT_W-1:0] dec_slot;
    logic                 cmd_wr;
    page_st_t             state;
    logic                 paged_eff;
    logic [PM_SLOT_W-1:0] slot_eff;

    pm_mode_latch u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_pin   (mode_pin),
        .first_mode (first_mode)
    );

    pm_cmd_decode #(
        .CMD_W      (CMD_W),
        .SLOTS      (PM_SLOTS),
        .PAGE_BASE  (PAGE_BASE),
        .CLEAR_CODE (CLEAR_CODE)
    ) u_dec (
        .cmd       (cmd_byte),
        .is_pagein (is_pagein),
        .is_clear  (is_clear),
        .slot      (dec_slot)
    );

    // Opcodes count only as writes to the auxiliary address in the second personality.
    always_comb begin
        cmd_wr = wr_stb && (host_addr == AUX_ADDR) && !first_mode;
    end

    pm_page_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .is_pagein (is_pagein),
        .is_clear  (is_clear),
        .slot_in   (dec_slot),
        .state     (state)
    );

    // Choose the paging source: pin in the first personality, opcodes otherwise.
    always_comb begin
        paged_eff = first_mode ? page_pin : state.active;
        slot_eff  = first_mode ? '0 : state.slot;
    end

    pm_addr_remap #(
        .ADDR_W    (ADDR_W),
        .SLOTS     (PM_SLOTS),
        .PAGE_ADDR (PAGE_ADDR),
        .PEER_ADDR (PEER_ADDR)
    ) u_remap (
        .first_mode (first_mode),
        .paged      (paged_eff),
        .slot       (slot_eff),
        .addr       (host_addr),
        .rd         (rd_stb),
        .wr         (wr_stb),
        .valid      (sel_valid_o),
        .hidden     (sel_hidden_o),
        .idx        (sel_idx_o)
    );

    // Expose page and personality state.
    always_comb begin
        page_active_o = paged_eff;
        page_slot_o   = slot_eff;
        first_mode_o  = first_mode;
    end

endmodule

// File: rtl/pm_checker.sv
// Cycle-level properties of the page mapper, attached by bind.
// Assumes the default parameter values of page_mapper.
module pm_checker #(
    parameter int                ADDR_W     = 5,
    parameter int                CMD_W      = 8,
    parameter logic [ADDR_W-1:0] AUX_ADDR   = 5'h05,
    parameter logic [ADDR_W-1:0] PAGE_ADDR  = 5'h0D,
    parameter logic [ADDR_W-1:0] PEER_ADDR  = 5'h0A,
    parameter logic [CMD_W-1:0]  PAGE_BASE  = 8'h50,
    parameter logic [CMD_W-1:0]  CLEAR_CODE = 8'h54
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          mode_pin,
    input logic                          page_pin,
    input logic [ADDR_W-1:0]             host_addr,
    input logic                          rd_stb,
    input logic                          wr_stb,
    input logic [CMD_W-1:0]              cmd_byte,
    input logic                          sel_valid_o,
    input logic                          sel_hidden_o,
    input logic [ADDR_W-1:0]             sel_idx_o,
    input logic                          page_active_o,
    input logic [pm_pkg::PM_SLOT_W-1:0]  page_slot_o,
    input logic                          first_mode_o
);

    logic aux_wr2;
    assign aux_wr2 = wr_stb && host_addr == AUX_ADDR && !first_mode_o;

    logic is_pin;
    logic is_clr;
    assign is_pin = cmd_byte >= PAGE_BASE && cmd_byte < PAGE_BASE + CMD_W'(pm_pkg::PM_SLOTS);
    assign is_clr = cmd_byte == CLEAR_CODE;

    assert_personality_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(first_mode_o));

    assert_unpaged_write_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_mode_o && !page_active_o && wr_stb && host_addr == PAGE_ADDR) |-> !sel_valid_o);

    assert_pagein_sets_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_wr2 && is_pin) |=> (page_active_o && page_slot_o == $past(cmd_byte[pm_pkg::PM_SLOT_W-1:0] - PAGE_BASE[pm_pkg::PM_SLOT_W-1:0])));

    assert_paged_read_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (page_active_o && rd_stb && !wr_stb && host_addr == PAGE_ADDR) |-> (sel_hidden_o && sel_idx_o == ADDR_W'(pm_pkg::PM_SLOTS)));

    assert_paged_read_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (page_active_o && rd_stb && !wr_stb && host_addr == PEER_ADDR) |-> (sel_hidden_o && sel_idx_o == ADDR_W'(pm_pkg::PM_SLOTS + 1)));

    assert_clear_pages_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_wr2 && is_clr) |=> !page_active_o);

    assert_other_code_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_wr2 && !is_pin && !is_clr) |=> ($stable(page_active_o) && $stable(page_slot_o)));

    assert_idle_no_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && !wr_stb) |-> !sel_valid_o);

    assert_pin_drives_paging_R9: assert property (@(posedge clk) disable iff (!rst_n)
        first_mode_o |-> (page_active_o == page_pin && page_slot_o == '0));

endmodule

bind page_mapper pm_checker u_pm_checker (.*);

// File: tb/test_page_mapper.sv
module test_page_mapper;

    localparam logic [4:0] AUX  = 5'h05;
    localparam logic [4:0] PG   = 5'h0D;
    localparam logic [4:0] PEER = 5'h0A;
    localparam int NV = 21;

    typedef struct packed {
        logic [1:0] op;      // 0 idle, 1 read, 2 write
        logic [4:0] addr;
        logic [7:0] data;
        logic       ev;      // expected sel_valid_o
        logic       eh;      // expected sel_hidden_o
        logic [4:0] ei;      // expected sel_idx_o
        logic       ea;      // expected page_active_o
        logic [1:0] es;      // expected page_slot_o
    } vec_t;

    // Second-personality sequence; expectations hold before the cycle's edge.
    localparam vec_t VECS [NV] = '{
        '{2'd2, PG,    8'h00, 1'b0, 1'b0, 5'h00, 1'b0, 2'd0}, // R3 unpaged write
        '{2'd1, PG,    8'h00, 1'b1, 1'b0, PG,    1'b0, 2'd0}, // R3 unpaged read
        '{2'd2, AUX,   8'h52, 1'b1, 1'b0, AUX,   1'b0, 2'd0}, // R4 page-in 2
        '{2'd2, PG,    8'h00, 1'b1, 1'b1, 5'd2,  1'b1, 2'd2}, // R4
        '{2'd1, PG,    8'h00, 1'b1, 1'b1, 5'd4,  1'b1, 2'd2}, // R6
        '{2'd1, PEER,  8'h00, 1'b1, 1'b1, 5'd5,  1'b1, 2'd2}, // R6
        '{2'd2, AUX,   8'h51, 1'b1, 1'b0, AUX,   1'b1, 2'd2}, // R5 replace
        '{2'd2, PG,    8'h00, 1'b1, 1'b1, 5'd1,  1'b1, 2'd1}, // R5
        '{2'd2, AUX,   8'h3C, 1'b1, 1'b0, AUX,   1'b1, 2'd1}, // R8 other code
        '{2'd2, PG,    8'h00, 1'b1, 1'b1, 5'd1,  1'b1, 2'd1}, // R8
        '{2'd2, AUX,   8'h55, 1'b1, 1'b0, AUX,   1'b1, 2'd1}, // R8 just past clear
        '{2'd2, PG,    8'h00, 1'b1, 1'b1, 5'd1,  1'b1, 2'd1}, // R8
        '{2'd2, AUX,   8'h54, 1'b1, 1'b0, AUX,   1'b1, 2'd1}, // R7 clear
        '{2'd2, PG,    8'h00, 1'b0, 1'b0, 5'h00, 1'b0, 2'd0}, // R7
        '{2'd1, PEER,  8'h00, 1'b1, 1'b0, PEER,  1'b0, 2'd0}, // R7
        '{2'd0, PG,    8'h00, 1'b0, 1'b0, 5'h00, 1'b0, 2'd0}, // R10 idle
        '{2'd2, 5'h13, 8'h00, 1'b1, 1'b0, 5'h13, 1'b0, 2'd0}, // R10 pass
        '{2'd2, AUX,   8'h50, 1'b1, 1'b0, AUX,   1'b0, 2'd0}, // R4 lowest code
        '{2'd2, PG,    8'h00, 1'b1, 1'b1, 5'd0,  1'b1, 2'd0}, // R4
        '{2'd2, AUX,   8'h53, 1'b1, 1'b0, AUX,   1'b1, 2'd0}, // R4 highest code
        '{2'd3, PG,    8'h00, 1'b1, 1'b1, 5'd3,  1'b1, 2'd3}  // R10 both strobes = write
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_pin = 1'b0;
    logic       page_pin = 1'b0;
    logic [4:0] host_addr = '0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       sel_valid_o, sel_hidden_o, page_active_o, first_mode_o;
    logic [4:0] sel_idx_o;
    logic [1:0] page_slot_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    page_mapper i_page_mapper (
        .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .page_pin(page_pin),
        .host_addr(host_addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .cmd_byte(cmd_byte),
        .sel_valid_o(sel_valid_o), .sel_hidden_o(sel_hidden_o), .sel_idx_o(sel_idx_o),
        .page_active_o(page_active_o), .page_slot_o(page_slot_o), .first_mode_o(first_mode_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one access after the falling edge and settle before sampling.
    task automatic drive(input logic [1:0] op, input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        rd_stb    = op[0];
        wr_stb    = op[1];
        host_addr = a;
        cmd_byte  = d;
        #1;
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
        mode_pin = mode;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        do_reset(1'b0);
        check("R1 reset active", page_active_o, 0);
        check("R1 reset slot", page_slot_o, 0);
        check("R2 second personality", first_mode_o, 0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].addr, VECS[i].data);
            check($sformatf("R3-R10 vec%0d valid", i), sel_valid_o, VECS[i].ev);
            check($sformatf("vec%0d hidden", i), sel_hidden_o, VECS[i].eh);
            if (VECS[i].ev) check($sformatf("vec%0d idx", i), sel_idx_o, VECS[i].ei);
            check($sformatf("vec%0d active", i), page_active_o, VECS[i].ea);
            check($sformatf("vec%0d slot", i), page_slot_o, VECS[i].es);
        end

        // R1: a page selected before reset is gone afterwards.
        drive(2'd0, 5'h00, 8'h00);
        check("R1 page held pre-reset", page_active_o, 1);
        do_reset(1'b0);
        check("R1 cleared by reset", page_active_o, 0);
        drive(2'd2, PG, 8'h00);
        check("R1 paging write none", sel_valid_o, 0);

        // R2: first personality captured; later pin changes ignored.
        do_reset(1'b1);
        check("R2 first personality", first_mode_o, 1);
        mode_pin = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check("R2 mode pin ignored", first_mode_o, 1);

        // R9: pin-driven paging in the first personality.
        drive(2'd2, PG, 8'h00);
        check("R9 unpaged write ordinary valid", sel_valid_o, 1);
        check("R9 unpaged write idx", sel_idx_o, PG);
        check("R9 unpaged hidden", sel_hidden_o, 0);
        page_pin = 1'b1;
        drive(2'd2, PG, 8'h00);
        check("R9 pin active", page_active_o, 1);
        check("R9 write hidden", sel_hidden_o, 1);
        check("R9 write idx 0", sel_idx_o, 0);
        drive(2'd1, PG, 8'h00);
        check("R9 read a", sel_idx_o, 4);
        drive(2'd1, PEER, 8'h00);
        check("R9 read b", sel_idx_o, 5);
        drive(2'd2, AUX, 8'h53);
        drive(2'd2, PG, 8'h00);
        check("R9 opcode ignored slot", page_slot_o, 0);
        check("R9 opcode ignored idx", sel_idx_o, 0);
        page_pin = 1'b0;
        drive(2'd2, AUX, 8'h52);
        drive(2'd2, PG, 8'h00);
        check("R9 pin low inactive", page_active_o, 0);
        check("R9 pin low ordinary", sel_hidden_o, 0);

        drive(2'd0, 5'h00, 8'h00);
        check("R10 idle none", sel_valid_o, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule